// File: doc/BRIEF.md
# PLL Holdover Controller

This block is the digital sequencer that protects the first stage of a clock PLL when its reference disappears. It watches a loss-of-signal input, a fast phase-error flag from the phase detector, the lock-detect input and a cycle-slip indication. It drives the charge-pump tristate enable, a reset pulse for the reference and feedback dividers, and the sense/force select of the tuning-voltage tracker.

Once the loop is locked, a confirmed loss of signal or an early phase-error flag puts the block into holdover, and the pump stays tristated. When the reference returns, one of three exit sequences runs. The choice comes from a criteria field and an action field. In the first sequence the block waits for a phase crossing and does not reset the dividers. In the second it resets the dividers and then releases the pump. In the third it resets the dividers while the tuning DAC is still forcing the tuning voltage, and hands control back to the loop only when the pump is released.

Top module: `pll_holdover_fsm`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, the block is in the locking state with the pump enabled. At that point `pump_tristate`, `div_reset`, `trk_force`, `in_holdover` and `locked` are all 0.
- R2: In the locking state, `lock_in`=1 moves the block to the locked state on the next edge, and `locked` then reads 1. In the locked state, a drop of `lock_in` without a reference fault returns the block to the locking state.
- R3: In the locked state, `ref_lost`=1 puts the block into holdover on the next edge. `in_holdover` and `pump_tristate` are then both 1, and stay at 1 for as long as `ref_lost` stays high.
- R4: In the locked state, `phase_err_fast`=1 sets `pump_tristate` and clears `locked` in the same cycle, before any clock edge. On the next edge the block holds the pump in holdover by itself, even if `ref_lost` is 0.
- R5: With `exit_crit`=1 and `exit_act`=1 (phase-crossing exit), the block leaves holdover for the exit-wait state once `ref_lost` falls. It then keeps the pump tristated until `slip_seen`=1, and releases it on the next edge. `div_reset` stays 0 throughout.
- R6: With `exit_crit`=0 and `exit_act`=0 (divider-reset exit), `div_reset` is high for exactly one cycle: the first cycle after the edge that sees `ref_lost`=0. The pump is released, and `in_holdover` falls, on the cycle after that pulse.
- R7: With `exit_crit`=0 and `exit_act`=3 (DAC-assisted exit), the divider pulse and release timing are those of R6. If force mode was engaged, `trk_force` stays 1 through the pulse cycle and returns to 0 when the pump is released.
- R8: If `use_dac`=1 at holdover entry, `trk_force` is 1 while the block is in holdover. If `use_dac` was 0 at entry, `trk_force` stays 0. In the reset and phase-crossing exits, `trk_force` returns to 0 as soon as the block leaves holdover for exit-wait.
- R9: Any other pair of criteria and action values behaves exactly like the divider-reset exit of R6, including the single `div_reset` pulse.
- R10: If `ref_lost` rises again in the exit-wait state, the block returns to holdover on the next edge, and `div_reset` stays 0 in that cycle.
- R11: In the reacquire state, `lock_in`=1 moves the block to the locked state. If `ref_lost`=1 arrives first, the block goes back to holdover instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lost | input | 1 | Reference loss-of-signal, confirmed |
| phase_err_fast | input | 1 | Phase-detector error wider than expected |
| lock_in | input | 1 | Lock detect from the loop |
| slip_seen | input | 1 | Cycle-slip indication (phase crossing) |
| use_dac | input | 1 | Engage tuning-DAC force mode during holdover |
| exit_crit | input | 2 | Holdover exit criteria field |
| exit_act | input | 2 | Holdover exit action field |
| pump_tristate | output | 1 | Charge pump tristated |
| div_reset | output | 1 | One-cycle reset pulse to the reference and feedback dividers |
| trk_force | output | 1 | Tracker in force mode (1) or sense mode (0) |
| in_holdover | output | 1 | High from holdover entry until the pump is released |
| locked | output | 1 | Qualified lock indication |

## Verification
The assertions check several properties on every cycle:
- the divider pulse lasts one cycle and is always followed by a released pump;
- holdover always implies a tristated pump;
- force mode never appears outside holdover;
- a qualified lock never coincides with a tristated pump;
- a loss of signal seen while locked always leads to holdover on the next edge.

Only the bench scenarios can show the decoding of the criteria and action fields into the three exit paths. The same holds for the fallback of unlisted field pairs, for the wait on a phase crossing, for return to holdover when the reference drops again during exit, and for the same-cycle response to the fast phase-error flag.

// File: rtl/pll_holdover_fsm.sv
module pll_holdover_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_lost,
  input  logic       phase_err_fast,
  input  logic       lock_in,
  input  logic       slip_seen,
  input  logic       use_dac,
  input  logic [1:0] exit_crit,
  input  logic [1:0] exit_act,
  output logic       pump_tristate,
  output logic       div_reset,
  output logic       trk_force,
  output logic       in_holdover,
  output logic       locked
);

  typedef enum logic [2:0] {
    S_LOCKING   = 3'd0,
    S_LOCKED    = 3'd1,
    S_HOLD      = 3'd2,
    S_EXIT_WAIT = 3'd3,
    S_REACQ     = 3'd4
  } state_t;

  typedef enum logic [1:0] {
    X_RESET = 2'd0,
    X_PHASE = 2'd1,
    X_DAC   = 2'd2
  } exit_t;

  state_t st, st_nxt;
  exit_t  mode_sel, mode_q;
  logic   dac_q;
  logic   enter_hold;

  always_comb begin
    if (exit_crit == 2'd1 && exit_act == 2'd1)      mode_sel = X_PHASE;
    else if (exit_crit == 2'd0 && exit_act == 2'd3) mode_sel = X_DAC;
    else                                            mode_sel = X_RESET;
  end

  always_comb begin
    st_nxt = st;
    case (st)
      S_LOCKING: if (lock_in) st_nxt = S_LOCKED;
      S_LOCKED: begin
        if (ref_lost || phase_err_fast) st_nxt = S_HOLD;
        else if (!lock_in)              st_nxt = S_LOCKING;
      end
      S_HOLD: if (!ref_lost) st_nxt = S_EXIT_WAIT;
      S_EXIT_WAIT: begin
        if (ref_lost)                            st_nxt = S_HOLD;
        else if (mode_q != X_PHASE || slip_seen) st_nxt = S_REACQ;
      end
      S_REACQ: begin
        if (ref_lost)     st_nxt = S_HOLD;
        else if (lock_in) st_nxt = S_LOCKED;
      end
      default: st_nxt = S_LOCKING;
    endcase
  end

  assign enter_hold = (st == S_LOCKED || st == S_REACQ) && st_nxt == S_HOLD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_LOCKING;
      mode_q <= X_RESET;
      dac_q  <= 1'b0;
    end else begin
      st <= st_nxt;
      if (enter_hold) dac_q <= use_dac;
      if (st == S_HOLD && !ref_lost) mode_q <= mode_sel;
    end
  end

  assign in_holdover   = (st == S_HOLD) || (st == S_EXIT_WAIT);
  assign pump_tristate = in_holdover || (st == S_LOCKED && phase_err_fast);
  assign div_reset     = (st == S_EXIT_WAIT) && (mode_q != X_PHASE) && !ref_lost;
  assign trk_force     = dac_q && ((st == S_HOLD) ||
                                   (st == S_EXIT_WAIT && mode_q == X_DAC));
  assign locked        = (st == S_LOCKED) && !phase_err_fast;

endmodule

// File: rtl/pll_holdover_fsm_sva.sv
module pll_holdover_fsm_sva (
  input logic clk,
  input logic rst_n,
  input logic ref_lost,
  input logic pump_tristate,
  input logic div_reset,
  input logic trk_force,
  input logic in_holdover,
  input logic locked
);

  p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |=> !div_reset);

  p_release_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |=> (!pump_tristate && !in_holdover));

  p_hold_tristate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_holdover |-> pump_tristate);

  p_force_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trk_force |-> in_holdover);

  p_lock_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!pump_tristate && !in_holdover));

  p_los_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ref_lost) |=> in_holdover);

endmodule

bind pll_holdover_fsm pll_holdover_fsm_sva u_sva (
  .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .pump_tristate(pump_tristate),
  .div_reset(div_reset), .trk_force(trk_force), .in_holdover(in_holdover),
  .locked(locked)
);

// File: tb/pll_holdover_fsm_tb.sv
`timescale 1ns/1ps
module pll_holdover_fsm_tb;
  logic clk = 1'b0;
  logic rst_n, ref_lost, phase_err_fast, lock_in, slip_seen, use_dac;
  logic [1:0] exit_crit, exit_act;
  logic pump_tristate, div_reset, trk_force, in_holdover, locked;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pll_holdover_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .phase_err_fast(phase_err_fast),
    .lock_in(lock_in), .slip_seen(slip_seen), .use_dac(use_dac),
    .exit_crit(exit_crit), .exit_act(exit_act), .pump_tristate(pump_tristate),
    .div_reset(div_reset), .trk_force(trk_force), .in_holdover(in_holdover),
    .locked(locked)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_lost = 1'b0; phase_err_fast = 1'b0; lock_in = 1'b0;
    slip_seen = 1'b0; use_dac = 1'b0; exit_crit = 2'd0; exit_act = 2'd0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic go_locked();
    lock_in = 1'b1;
    step();
    chk(locked, 1'b1, "R2 locked after lock_in");
  endtask

  task automatic go_hold();
    ref_lost = 1'b1; lock_in = 1'b0;
    step();
    chk(in_holdover, 1'b1, "R3 in_holdover on entry");
    chk(pump_tristate, 1'b1, "R3 pump tristate on entry");
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(pump_tristate, 1'b0, "R1 pump_tristate");
    chk(div_reset, 1'b0, "R1 div_reset");
    chk(trk_force, 1'b0, "R1 trk_force");
    chk(in_holdover, 1'b0, "R1 in_holdover");
    chk(locked, 1'b0, "R1 locked");
    step();
    chk(locked, 1'b0, "R1 still locking without lock_in");
  endtask

  task automatic t_lock_loss();
    do_reset();
    go_locked();
    lock_in = 1'b0;
    step();
    chk(locked, 1'b0, "R2 back to locking on lock loss");
    chk(in_holdover, 1'b0, "R2 no holdover on lock loss");
    lock_in = 1'b1;
    step();
    chk(locked, 1'b1, "R2 relock");
  endtask

  task automatic t_reset_exit();
    do_reset();
    go_locked();
    go_hold();
    repeat (3) step();
    chk(pump_tristate, 1'b1, "R3 pump held while LOS high");
    chk(div_reset, 1'b0, "R6 no pulse during holdover");
    ref_lost = 1'b0;
    step();
    chk(div_reset, 1'b1, "R6 divider pulse");
    chk(pump_tristate, 1'b1, "R6 pump tristate during pulse");
    step();
    chk(div_reset, 1'b0, "R6 pulse single cycle");
    chk(pump_tristate, 1'b0, "R6 pump released after pulse");
    chk(in_holdover, 1'b0, "R6 in_holdover low at release");
  endtask

  task automatic t_phase_exit();
    do_reset();
    exit_crit = 2'd1; exit_act = 2'd1;
    go_locked();
    go_hold();
    ref_lost = 1'b0;
    step();
    chk(div_reset, 1'b0, "R5 no divider reset");
    repeat (4) begin
      step();
      chk(pump_tristate, 1'b1, "R5 pump waits for slip");
      chk(div_reset, 1'b0, "R5 no divider reset while waiting");
    end
    slip_seen = 1'b1;
    step();
    slip_seen = 1'b0;
    chk(pump_tristate, 1'b0, "R5 release after slip");
    chk(div_reset, 1'b0, "R5 no pulse at release");
    lock_in = 1'b1;
    step();
    chk(locked, 1'b1, "R11 reacquire to locked");
  endtask

  task automatic t_dac_exit();
    do_reset();
    use_dac = 1'b1; exit_crit = 2'd0; exit_act = 2'd3;
    go_locked();
    go_hold();
    chk(trk_force, 1'b1, "R8 force in holdover");
    use_dac = 1'b0;
    ref_lost = 1'b0;
    step();
    chk(div_reset, 1'b1, "R7 divider pulse");
    chk(trk_force, 1'b1, "R7 force held through pulse");
    step();
    chk(trk_force, 1'b0, "R7 sense at release");
    chk(pump_tristate, 1'b0, "R7 pump released");
  endtask

  task automatic t_force_modes();
    do_reset();
    use_dac = 1'b1;
    go_locked();
    go_hold();
    chk(trk_force, 1'b1, "R8 force with use_dac");
    ref_lost = 1'b0;
    step();
    chk(trk_force, 1'b0, "R8 force drops in reset exit");
    step();
    do_reset();
    go_locked();
    go_hold();
    chk(trk_force, 1'b0, "R8 no force without use_dac");
  endtask

  task automatic t_fast_err();
    do_reset();
    go_locked();
    phase_err_fast = 1'b1;
    #1;
    chk(pump_tristate, 1'b1, "R4 same-cycle tristate");
    chk(locked, 1'b0, "R4 lock invalidated");
    step();
    phase_err_fast = 1'b1;
    chk(in_holdover, 1'b1, "R4 holdover after flag");
    phase_err_fast = 1'b0;
    ref_lost = 1'b1;
    step();
    chk(pump_tristate, 1'b1, "R4 FSM keeps pump tristated");
    ref_lost = 1'b0;
    step();
    chk(div_reset, 1'b1, "R4 exit pulse follows");
    step();
  endtask

  task automatic t_odd_combo();
    do_reset();
    exit_crit = 2'd2; exit_act = 2'd1;
    go_locked();
    go_hold();
    ref_lost = 1'b0;
    step();
    chk(div_reset, 1'b1, "R9 unlisted pair pulses dividers");
    step();
    chk(div_reset, 1'b0, "R9 single pulse");
    chk(pump_tristate, 1'b0, "R9 released");
  endtask

  task automatic t_los_return();
    do_reset();
    exit_crit = 2'd1; exit_act = 2'd1;
    go_locked();
    go_hold();
    ref_lost = 1'b0;
    step();
    ref_lost = 1'b1;
    #1;
    chk(div_reset, 1'b0, "R10 no pulse on LOS return");
    step();
    chk(in_holdover, 1'b1, "R10 back in holdover");
    slip_seen = 1'b1;
    step();
    slip_seen = 1'b0;
    chk(pump_tristate, 1'b1, "R10 slip ignored while LOS high");
  endtask

  task automatic t_reacq_los();
    do_reset();
    go_locked();
    go_hold();
    ref_lost = 1'b0;
    step();
    step();
    chk(in_holdover, 1'b0, "R11 in reacquire");
    ref_lost = 1'b1;
    step();
    chk(in_holdover, 1'b1, "R11 LOS in reacquire returns to holdover");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_lock_loss();
    t_reset_exit();
    t_phase_exit();
    t_dac_exit();
    t_force_modes();
    t_fast_err();
    t_odd_combo();
    t_los_return();
    t_reacq_los();
    finish_run();
  end
endmodule